// File: doc/BRIEF.md
# Periodic Card-Bus Refresh Master

This block is the sole master of a shared serial bus that links a set of output/input cards. On a fixed cadence it walks a configuration table, one entry per card, and sends each card one frame: the card's output data bytes first, then the card's address byte last, followed by a latch pulse. Every card on the bus shifts in every frame, but only the card whose address matches the final byte moves the data bytes to its outputs. That card also loads its input bytes, which it then shifts back to the master on a return line during the next frame.

The block therefore collects each card's inputs one frame late. When the card just addressed has more input bytes than the next frame has bytes, the block puts filler bytes at the front of that frame to supply enough clock pulses. When the card has fewer, the surplus returned bits are dropped. A final frame to an unused address closes every pass so that the last real card's inputs are also collected. The table is external: the block presents a card index and a data byte index, and reads the entry over a combinational read port. Captured input bytes go back out on a one-cycle write strobe.

The bus bit rate is set by `HALF_DIV` (system clocks per half bit; the default of 80 gives 312.5 kHz from a 50 MHz clock). The pass rate is set by `PASS_PERIOD` (the default gives 80 passes per second from the same clock).

Top module: `bsched_top`

## Requirements
- R1: One bus bit lasts 2*HALF_DIV system clocks. `sclk` is low for the first HALF_DIV clocks and high for the next HALF_DIV. `txd` changes only while `sclk` is low. Each byte is sent most significant bit first.
- R2: The frame for card k carries, in order: the filler bytes, the card's data bytes with indexes 0 to nout-1 (read through `tbl_byte`), and the card's address byte last. Filler bytes have the value FILL_BYTE.
- R3: After the last bit of a frame, `strobe` is high for exactly 2*HALF_DIV clocks. During that time `sclk` and `txd` are low.
- R4: The number of filler bytes is prev_nin - (nout+1) when that difference is positive, and zero otherwise. Here prev_nin is the input byte count of the card sent in the previous frame of the same pass. For the first frame of a pass, prev_nin is 0.
- R5: While frame k+1 is sent, `rxd` is sampled on the clock where `sclk` is about to rise. The first 8*nin[k] bits form input bytes 0, 1, ... of card k, most significant bit first. Each byte is written out with `in_we`=1, `in_card`=k, `in_byte`=byte index.
- R6: Returned bits beyond the previous card's input byte count produce no write, and no write names a card or byte outside the configured range.
- R7: Each pass ends with one extra frame. It has no data bytes, its address byte is DUMMY_ADDR, and it follows the filler rule of R4. No frame follows it in that pass. With `num_cards`=0 a pass consists of this frame alone.
- R8: A pass starts every PASS_PERIOD clocks from an internal tick. Within a pass, frames follow table index order 0 to `num_cards`-1. `num_cards` is sampled when the pass starts.
- R9: A tick that arrives while a pass is in progress sets `overrun`, which then stays 1 until reset. The running pass continues unchanged, and that tick does not start another pass.
- R10: During and after reset, `sclk`, `txd`, `strobe`, `in_we` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| num_cards | input | $clog2(MAX_CARDS+1) | Number of table entries in use |
| tbl_card | output | $clog2(MAX_CARDS+1) | Table entry being read |
| tbl_byte | output | max(1,$clog2(MAX_OUT)) | Output data byte index being read |
| tbl_addr | input | 8 | Address byte of the entry |
| tbl_nout | input | $clog2(MAX_OUT+1) | Output data byte count of the entry |
| tbl_nin | input | $clog2(MAX_IN+1) | Input byte count of the entry |
| tbl_data | input | 8 | Output data byte selected by tbl_byte |
| sclk | output | 1 | Bus bit clock |
| txd | output | 1 | Bus transmit data |
| strobe | output | 1 | Bus latch pulse |
| rxd | input | 1 | Bus return data |
| in_we | output | 1 | Captured input byte write strobe |
| in_card | output | $clog2(MAX_CARDS+1) | Card the captured byte belongs to |
| in_byte | output | max(1,$clog2(MAX_IN)) | Input byte index |
| in_data | output | 8 | Captured input byte |
| overrun | output | 1 | Sticky pass overrun flag |

## Verification
The bus outputs are decoded from state registers, so each one settles in the clock after the edge that moves the state. The bench samples every output at the falling system clock edge and rebuilds frames from `txd` at each observed `sclk` rise. The bench acts as the cards: it changes `rxd` at the falling edge after an `sclk` rise. The master samples `rxd` in the last low clock before the following rise, which leaves the bit one full half-period to settle. Each input byte write appears one clock after its eighth sample, while the frame is still being shifted. Pass start is measured at the first `sclk` rise, and the checks compare the spacing between passes with PASS_PERIOD.

// File: rtl/bsched_pkg.sv
package bsched_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_START,
        ST_SHIFT,
        ST_STROBE
    } sched_state_e;

    typedef enum logic [1:0] {
        SRC_FILL,
        SRC_DATA,
        SRC_ADDR
    } byte_src_e;

    // Per-frame parameters, latched once when a frame is set up
    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] nout;
        logic [7:0] nin;
        logic [7:0] pad;
        logic [7:0] total;
    } frame_t;

    // Filler bytes needed so the previous card can return all its inputs
    function automatic logic [7:0] pad_bytes(input logic [7:0] prev_in,
                                             input logic [7:0] nout);
        logic [8:0] flen;
        logic [8:0] diff;
        flen = {1'b0, nout} + 9'd1;
        diff = {1'b0, prev_in} - flen;
        if ({1'b0, prev_in} > flen)
            return diff[7:0];
        return 8'd0;
    endfunction

    // Which kind of byte sits at a given position in the frame
    function automatic byte_src_e byte_source(input logic [7:0] idx,
                                              input logic [7:0] pad,
                                              input logic [7:0] nout);
        logic [8:0] data_end;
        data_end = {1'b0, pad} + {1'b0, nout};
        if (idx < pad)
            return SRC_FILL;
        if ({1'b0, idx} < data_end)
            return SRC_DATA;
        return SRC_ADDR;
    endfunction

endpackage

// File: rtl/bsched_tick.sv
module bsched_tick #(
    parameter int PERIOD = 625000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int TW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/bsched_bit_timer.sv
module bsched_bit_timer #(
    parameter int HALF = 80
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sample,
    output logic bit_end,
    output logic high
);
    localparam int TW = (2 * HALF > 2) ? $clog2(2 * HALF) : 1;
    localparam logic [TW-1:0] LAST    = TW'(2 * HALF - 1);
    localparam logic [TW-1:0] SAMPLE  = TW'(HALF - 1);
    localparam logic [TW-1:0] HI_FROM = TW'(HALF);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign sample  = run && (cnt_q == SAMPLE);
    assign bit_end = run && (cnt_q == LAST);
    assign high    = run && (cnt_q >= HI_FROM);
endmodule

// File: rtl/bsched_rx_deser.sv
module bsched_rx_deser (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       sample,
    input  logic       rxd,
    output logic       byte_valid,
    output logic [7:0] byte_data
);
    logic [7:0] sh_q;
    logic [2:0] cnt_q;
    logic       valid_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sh_q    <= '0;
            cnt_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= sample && (cnt_q == 3'd7);
            if (sample) begin
                sh_q  <= {sh_q[6:0], rxd};
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign byte_valid = valid_q;
    assign byte_data  = sh_q;
endmodule

// File: rtl/bsched_top.sv
module bsched_top
    import bsched_pkg::*;
#(
    parameter int         MAX_CARDS   = 32,
    parameter int         MAX_OUT     = 4,
    parameter int         MAX_IN      = 8,
    parameter int         HALF_DIV    = 80,
    parameter int         PASS_PERIOD = 625000,
    parameter logic [7:0] DUMMY_ADDR  = 8'hFF,
    parameter logic [7:0] FILL_BYTE   = 8'h00,
    localparam int CW  = $clog2(MAX_CARDS + 1),
    localparam int OW  = $clog2(MAX_OUT + 1),
    localparam int IW  = $clog2(MAX_IN + 1),
    localparam int OSW = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1,
    localparam int ISW = (MAX_IN > 1) ? $clog2(MAX_IN) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [CW-1:0]  num_cards,
    output logic [CW-1:0]  tbl_card,
    output logic [OSW-1:0] tbl_byte,
    input  logic [7:0]     tbl_addr,
    input  logic [OW-1:0]  tbl_nout,
    input  logic [IW-1:0]  tbl_nin,
    input  logic [7:0]     tbl_data,
    output logic           sclk,
    output logic           txd,
    output logic           strobe,
    input  logic           rxd,
    output logic           in_we,
    output logic [CW-1:0]  in_card,
    output logic [ISW-1:0] in_byte,
    output logic [7:0]     in_data,
    output logic           overrun
);

    sched_state_e   st_q;
    logic [CW-1:0]  card_q;
    logic [CW-1:0]  num_q;
    logic [7:0]     prev_in_q;
    frame_t         fr_q;
    frame_t         fr_next;
    logic [7:0]     ld_cnt_q;
    logic [OSW-1:0] data_sel_q;
    logic [2:0]     bit_q;
    logic [7:0]     sh_q;
    logic [7:0]     rx_cnt_q;
    logic           overrun_q;

    logic           tick;
    logic           run_timer;
    logic           sample;
    logic           bit_end;
    logic           high;
    logic           rx_valid;
    logic [7:0]     rx_byte;
    logic           is_dummy;
    byte_src_e      src;
    logic [7:0]     next_byte;

    bsched_tick #(.PERIOD(PASS_PERIOD)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    assign run_timer = (st_q == ST_SHIFT) || (st_q == ST_STROBE);

    bsched_bit_timer #(.HALF(HALF_DIV)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (run_timer),
        .sample  (sample),
        .bit_end (bit_end),
        .high    (high)
    );

    bsched_rx_deser u_rx (
        .clk        (clk),
        .rst        (rst),
        .clear      (st_q == ST_LOAD),
        .sample     (sample && (st_q == ST_SHIFT)),
        .rxd        (rxd),
        .byte_valid (rx_valid),
        .byte_data  (rx_byte)
    );

    // Frame setup from the table entry (or the closing frame)
    always_comb begin
        is_dummy      = (card_q == num_q);
        fr_next.addr  = is_dummy ? DUMMY_ADDR : tbl_addr;
        fr_next.nout  = is_dummy ? 8'd0 : 8'(tbl_nout);
        fr_next.nin   = is_dummy ? 8'd0 : 8'(tbl_nin);
        fr_next.pad   = pad_bytes(prev_in_q, fr_next.nout);
        fr_next.total = fr_next.pad + fr_next.nout + 8'd1;
    end

    // Byte to load next into the transmit shifter
    always_comb begin
        src = byte_source(ld_cnt_q, fr_q.pad, fr_q.nout);
        case (src)
            SRC_FILL: next_byte = FILL_BYTE;
            SRC_DATA: next_byte = tbl_data;
            default:  next_byte = fr_q.addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            card_q     <= '0;
            num_q      <= '0;
            prev_in_q  <= '0;
            fr_q       <= '0;
            ld_cnt_q   <= '0;
            data_sel_q <= '0;
            bit_q      <= '0;
            sh_q       <= '0;
            rx_cnt_q   <= '0;
            overrun_q  <= 1'b0;
        end else begin
            if (tick && (st_q != ST_IDLE))
                overrun_q <= 1'b1;
            if (rx_valid)
                rx_cnt_q <= rx_cnt_q + 1'b1;
            case (st_q)
                ST_IDLE: begin
                    if (tick) begin
                        num_q     <= num_cards;
                        card_q    <= '0;
                        prev_in_q <= '0;
                        st_q      <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    fr_q       <= fr_next;
                    ld_cnt_q   <= '0;
                    data_sel_q <= '0;
                    rx_cnt_q   <= '0;
                    st_q       <= ST_START;
                end
                ST_START: begin
                    sh_q     <= next_byte;
                    ld_cnt_q <= ld_cnt_q + 1'b1;
                    if (src == SRC_DATA)
                        data_sel_q <= data_sel_q + 1'b1;
                    bit_q <= '0;
                    st_q  <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (bit_end) begin
                        if (bit_q == 3'd7) begin
                            if (ld_cnt_q == fr_q.total) begin
                                st_q <= ST_STROBE;
                            end else begin
                                sh_q     <= next_byte;
                                ld_cnt_q <= ld_cnt_q + 1'b1;
                                if (src == SRC_DATA)
                                    data_sel_q <= data_sel_q + 1'b1;
                            end
                            bit_q <= '0;
                        end else begin
                            sh_q  <= {sh_q[6:0], 1'b0};
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                ST_STROBE: begin
                    if (bit_end) begin
                        if (card_q == num_q) begin
                            st_q <= ST_IDLE;
                        end else begin
                            prev_in_q <= fr_q.nin;
                            card_q    <= card_q + 1'b1;
                            st_q      <= ST_LOAD;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign tbl_card = card_q;
    assign tbl_byte = data_sel_q;

    assign sclk   = (st_q == ST_SHIFT) && high;
    assign txd    = (st_q == ST_SHIFT) && sh_q[7];
    assign strobe = (st_q == ST_STROBE);

    assign in_we   = rx_valid && (rx_cnt_q < prev_in_q);
    assign in_card = card_q - 1'b1;
    assign in_byte = rx_cnt_q[ISW-1:0];
    assign in_data = rx_byte;
    assign overrun = overrun_q;

endmodule

// File: rtl/bsched_chk.sv
module bsched_chk #(
    parameter int HALF = 80
) (
    input logic clk,
    input logic rst,
    input logic sclk,
    input logic txd,
    input logic strobe,
    input logic in_we,
    input logic overrun
);
    localparam logic [15:0] HI_LEN = 16'(HALF);
    localparam logic [15:0] ST_LEN = 16'(2 * HALF);

    logic [15:0] hi_len_q;
    logic [15:0] st_len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_len_q <= '0;
            st_len_q <= '0;
        end else begin
            hi_len_q <= sclk ? hi_len_q + 16'd1 : 16'd0;
            st_len_q <= strobe ? st_len_q + 16'd1 : 16'd0;
        end
    end

    // R1
    txd_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(txd));

    // R1
    sclk_high_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> (hi_len_q == HI_LEN));

    // R3
    strobe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |-> (!sclk && !txd));

    // R3
    strobe_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe) |-> (st_len_q == ST_LEN));

    // R5
    write_in_shift_chk: assert property (@(posedge clk) disable iff (rst)
        in_we |-> !strobe);

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

endmodule

bind bsched_top bsched_chk #(.HALF(HALF_DIV)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sclk    (sclk),
    .txd     (txd),
    .strobe  (strobe),
    .in_we   (in_we),
    .overrun (overrun)
);

// File: tb/bsched_top_bench.sv
`timescale 1ns/1ps
module bsched_top_bench;
    localparam int         NC    = 8;
    localparam int         NO    = 4;
    localparam int         NI    = 4;
    localparam int         HALF  = 2;
    localparam int         PER   = 1000;
    localparam logic [7:0] DUMMY = 8'hFF;
    localparam logic [7:0] FILL  = 8'h00;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] num_cards = '0;
    logic [3:0] tbl_card;
    logic [1:0] tbl_byte;
    logic [7:0] tbl_addr;
    logic [2:0] tbl_nout;
    logic [2:0] tbl_nin;
    logic [7:0] tbl_data;
    logic       sclk, txd, strobe, rxd;
    logic       in_we;
    logic [3:0] in_card;
    logic [1:0] in_byte;
    logic [7:0] in_data;
    logic       overrun;

    always #2.5 clk = ~clk;

    bsched_top #(
        .MAX_CARDS(NC), .MAX_OUT(NO), .MAX_IN(NI), .HALF_DIV(HALF),
        .PASS_PERIOD(PER), .DUMMY_ADDR(DUMMY), .FILL_BYTE(FILL)
    ) u_bsched_top (
        .clk(clk), .rst(rst), .num_cards(num_cards),
        .tbl_card(tbl_card), .tbl_byte(tbl_byte), .tbl_addr(tbl_addr),
        .tbl_nout(tbl_nout), .tbl_nin(tbl_nin), .tbl_data(tbl_data),
        .sclk(sclk), .txd(txd), .strobe(strobe), .rxd(rxd),
        .in_we(in_we), .in_card(in_card), .in_byte(in_byte),
        .in_data(in_data), .overrun(overrun)
    );

    // Configuration table model
    logic [7:0] t_addr [NC];
    logic [2:0] t_nout [NC];
    logic [2:0] t_nin  [NC];
    logic [7:0] t_out  [NC][NO];
    logic [7:0] t_in   [NC][NI];

    always_comb begin
        if (int'(tbl_card) < NC) begin
            tbl_addr = t_addr[tbl_card];
            tbl_nout = t_nout[tbl_card];
            tbl_nin  = t_nin[tbl_card];
            tbl_data = t_out[tbl_card][tbl_byte];
        end else begin
            tbl_addr = 8'h00;
            tbl_nout = 3'd0;
            tbl_nin  = 3'd0;
            tbl_data = 8'h00;
        end
    end

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Bus monitor and card model records
    int         cyc = 0;
    int         nfr = 0;
    int         nbits = 0;
    logic [7:0] cur = '0;
    logic [7:0] fb [16][8];
    int         flen [16];
    int         start_t = 0;
    int         hi_len = 0;
    int         st_len = 0;
    int         r1_err = 0;
    int         r3_err = 0;
    int         bad_wr = 0;
    int         wcount = 0;
    int         sel = -1;
    int         ptr = 0;
    int         cur_n = 0;
    logic       sclk_p = 0, txd_p = 0, strobe_p = 0;
    logic [7:0] got   [NC][NI];
    bit         got_v [NC][NI];
    logic       rxd_r = 1'b1;

    assign rxd = rxd_r;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst) begin
            if (sclk && !sclk_p) begin
                if (nfr == 0 && nbits == 0) start_t = cyc;
                cur   = {cur[6:0], txd};
                nbits = nbits + 1;
                if (nbits % 8 == 0 && nfr < 16 && nbits / 8 <= 8)
                    fb[nfr][nbits / 8 - 1] = cur;
                ptr = ptr + 1;
                hi_len = 1;
            end else if (sclk) begin
                hi_len = hi_len + 1;
                if (txd != txd_p) r1_err = r1_err + 1;
            end
            if (!sclk && sclk_p && hi_len != HALF) r1_err = r1_err + 1;
            if (strobe && !strobe_p) begin
                if (nbits % 8 != 0) r1_err = r1_err + 1;
                if (nfr < 16) flen[nfr] = nbits / 8;
                nfr   = nfr + 1;
                nbits = 0;
                sel   = -1;
                for (int k = 0; k < cur_n; k++)
                    if (t_addr[k] == cur) sel = k;
                ptr    = 0;
                st_len = 0;
            end
            if (strobe) begin
                st_len = st_len + 1;
                if (sclk || txd) r3_err = r3_err + 1;
            end
            if (!strobe && strobe_p && st_len != 2 * HALF) r3_err = r3_err + 1;
            if (in_we) begin
                wcount = wcount + 1;
                if (int'(in_card) >= cur_n) bad_wr = bad_wr + 1;
                else if (int'(in_byte) >= int'(t_nin[in_card])) bad_wr = bad_wr + 1;
                else begin
                    got[in_card][in_byte]   = in_data;
                    got_v[in_card][in_byte] = 1'b1;
                end
            end
        end
        if (sel >= 0 && ptr < 8 * int'(t_nin[sel]))
            rxd_r = t_in[sel][ptr / 8][7 - (ptr % 8)];
        else
            rxd_r = 1'b1;
        sclk_p   = sclk;
        txd_p    = txd;
        strobe_p = strobe;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_rec();
        nfr = 0; nbits = 0; wcount = 0; bad_wr = 0;
        for (int k = 0; k < NC; k++)
            for (int i = 0; i < NI; i++) got_v[k][i] = 1'b0;
    endtask

    // Waits for one whole pass with n cards; returns its start cycle
    task automatic run_pass(input int n, output int t0);
        int waited = 0;
        cur_n = n;
        num_cards = 4'(n);
        clear_rec();
        while (!(nfr == n + 1 && !strobe) && waited < 6000) begin
            @(negedge clk);
            waited = waited + 1;
        end
        repeat (2) @(negedge clk);
        t0 = start_t;
    endtask

    // Checks frame layout and captured inputs against the table (R2 R4 R5 R6 R7)
    task automatic check_pass(input int n, input string name);
        int prev = 0;
        int total_in = 0;
        check(nfr == n + 1, "R7", {name, " frame count"}, nfr, n + 1);
        for (int k = 0; k <= n && k < nfr; k++) begin
            int no  = (k < n) ? int'(t_nout[k]) : 0;
            int pad = (prev > no + 1) ? prev - no - 1 : 0;
            int len = pad + no + 1;
            int bad = -1;
            logic [7:0] exp_b [8];
            for (int j = 0; j < pad; j++) exp_b[j] = FILL;
            for (int j = 0; j < no; j++) exp_b[pad + j] = t_out[k][j];
            exp_b[len - 1] = (k < n) ? t_addr[k] : DUMMY;
            check(flen[k] == len, "R4", $sformatf("%s frame %0d length", name, k), flen[k], len);
            if (flen[k] == len)
                for (int j = 0; j < len; j++)
                    if (bad < 0 && fb[k][j] != exp_b[j]) bad = j;
            if (k == n)
                check(bad < 0, "R7", $sformatf("%s closing frame byte %0d", name, bad),
                      bad < 0 ? 0 : int'(fb[k][bad]), bad < 0 ? 0 : int'(exp_b[bad]));
            else
                check(bad < 0, "R2", $sformatf("%s frame %0d byte %0d", name, k, bad),
                      bad < 0 ? 0 : int'(fb[k][bad]), bad < 0 ? 0 : int'(exp_b[bad]));
            prev = (k < n) ? int'(t_nin[k]) : 0;
        end
        for (int k = 0; k < n; k++) begin
            int bad = -1;
            total_in = total_in + int'(t_nin[k]);
            for (int i = 0; i < int'(t_nin[k]); i++)
                if (bad < 0 && (!got_v[k][i] || got[k][i] != t_in[k][i])) bad = i;
            check(bad < 0, "R5", $sformatf("%s inputs card %0d byte %0d", name, k, bad),
                  bad < 0 ? 0 : int'(got[k][bad]), bad < 0 ? 0 : int'(t_in[k][bad]));
        end
        check(wcount == total_in && bad_wr == 0, "R6", {name, " input write count"},
              wcount, total_in);
        check(r1_err == 0, "R1", {name, " bit timing"}, r1_err, 0);
        check(r3_err == 0, "R3", {name, " strobe timing"}, r3_err, 0);
    endtask

    task automatic set_card(input int k, input logic [7:0] a, input int no, input int ni,
                            input logic [7:0] seed);
        t_addr[k] = a;
        t_nout[k] = 3'(no);
        t_nin[k]  = 3'(ni);
        for (int j = 0; j < NO; j++) t_out[k][j] = seed + 8'(17 * j + 3);
        for (int j = 0; j < NI; j++) t_in[k][j]  = ~seed ^ 8'(29 * j + 5);
    endtask

    int t_a, t_b, t_c, t_d;

    // R10: outputs quiet out of reset
    task automatic test_reset();
        check(!sclk && !txd && !strobe, "R10", "bus idle after reset",
              {sclk, txd, strobe}, 0);
        check(!in_we && !overrun, "R10", "write and overrun low after reset",
              {in_we, overrun}, 0);
    endtask

    // R2 R4 R5 R6: equal, fewer, and more input bytes than the next frame
    task automatic test_mixed();
        set_card(0, 8'h21, 2, 2, 8'h10);
        set_card(1, 8'h42, 1, 4, 8'h20);
        set_card(2, 8'h13, 1, 1, 8'h30);
        set_card(3, 8'h37, 3, 2, 8'h40);
        run_pass(4, t_a);
        check_pass(4, "mixed");
    endtask

    // R4 R8: first frame gets no filler though the last card had inputs
    task automatic test_reordered();
        set_card(0, 8'h05, 0, 4, 8'h51);
        set_card(1, 8'h66, 2, 0, 8'h62);
        set_card(2, 8'h7A, 0, 4, 8'h73);
        run_pass(3, t_b);
        check_pass(3, "reordered");
        check(t_b - t_a == PER, "R8", "pass spacing", t_b - t_a, PER);
        run_pass(3, t_c);
        check_pass(3, "repeat");
        check(t_c - t_b == PER, "R8", "pass spacing repeat", t_c - t_b, PER);
    endtask

    // R7: empty table still sends the closing frame alone
    task automatic test_empty();
        run_pass(0, t_a);
        check_pass(0, "empty");
        check(overrun == 1'b0, "R9", "no overrun for short passes", overrun, 0);
    endtask

    // R9: long pass overruns, continues unchanged and skips the missed tick
    task automatic test_overrun();
        for (int k = 0; k < NC; k++) set_card(k, 8'(8'h80 + k), NO, NI, 8'(8'h90 + 7 * k));
        run_pass(NC, t_b);
        check_pass(NC, "long");
        check(overrun == 1'b1, "R9", "overrun set by long pass", overrun, 1);
        check(t_b - t_a == PER, "R8", "long pass start", t_b - t_a, PER);
        set_card(0, 8'h11, 1, 1, 8'hA0);
        run_pass(1, t_d);
        check_pass(1, "after overrun");
        check(t_d - t_b == 2 * PER, "R9", "missed tick starts no pass", t_d - t_b, 2 * PER);
        check(overrun == 1'b1, "R9", "overrun sticky", overrun, 1);
    endtask

    initial begin
        for (int k = 0; k < NC; k++) set_card(k, 8'(k + 1), 0, 0, 8'h00);
        repeat (5) @(negedge clk);
        test_reset();
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_mixed();
        test_reordered();
        test_empty();
        test_overrun();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule